// File: doc/BRIEF.md
# ADC Conversion Sequencer with Trigger Selection and Ready Tracking

This block drives an analog-to-digital converter on a bus-mapped acquisition card. A conversion can be started by one of three sources: a write to a dedicated trigger register, a periodic pacer built from two cascaded down-counters, or a rising edge on an external input pin. The block issues a one-cycle start pulse to the converter, tracks the conversion until the converter returns its done strobe with a data word, latches that word and raises a data-ready flag. Reading the data register clears the flag.

A completion is reported in one of three ways, chosen by two control bits. With neither bit set, software polls the ready bit. With the interrupt bit set, an interrupt line stays high while a result waits. With the DMA bit set, a one-cycle request pulse goes out per completion and the interrupt line stays low. A trigger that arrives while a conversion is still outstanding starts nothing and sets a sticky overrun bit.

Registers, word offsets on a 5-bit address: result 0x00 (read), status 0x04 (read), pacer stage-0 reload 0x08, pacer stage-1 reload 0x0C, software trigger 0x14 (write), control 0x18. Control bits: [1:0] trigger source (00 software, 01 pacer, 10 external pin, 11 off), [2] interrupt enable, [3] DMA enable. Status bits: [0] ready, [1] overrun, [2] busy. Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With source 00, a write of any data value to offset 0x14 causes exactly one `adc_start_o` pulse, one cycle wide, in the cycle after the write.
- R2: With source 01, start pulses repeat every P0*P1 cycles, where P0 and P1 are the 16-bit reload values at 0x08 and 0x0C and a reload of 0 counts as 65536; stage 1 steps only on stage 0's terminal count and both stages reload on their own.
- R3: With source 10, each rising edge of `ext_trig_i` gives exactly one start pulse, however long the input stays high; the pin passes through two synchronizing flops first.
- R4: A trigger that arrives while a conversion is outstanding issues no start and sets status bit 1; the bit is cleared by a read of offset 0x04 (a new overrun in the same cycle wins).
- R5: Status bit 0 goes high in the cycle after a done strobe accepted while busy, and is cleared by a read of offset 0x00, which returns the latched converter word; a completion in the same cycle wins.
- R6: With control bit 2 set and bit 3 clear, `irq_o` is high exactly while status bit 0 is high.
- R7: With control bit 3 set, `dma_req_o` gives one one-cycle pulse per completion and `irq_o` stays low regardless of bit 2.
- R8: With source 11 no conversion starts; a write to 0x14 while the source is not 00 starts nothing.
- R9: Status bit 2 reads 1 from the start pulse until the done strobe is accepted; the converter must answer within CONV_MAX_CYC cycles of the start, and a done strobe while idle is ignored.
- R10: After reset, all outputs are 0, the source is 00, both enables are clear and all status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data, valid the cycle after `bus_rd` |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| adc_start_o | output | 1 | One-cycle start pulse to the converter |
| adc_done_i | input | 1 | Converter done strobe |
| adc_data_i | input | DATA_W | Converter result, valid with `adc_done_i` |
| irq_o | output | 1 | Level interrupt request |
| dma_req_o | output | 1 | One-cycle DMA request pulse |

## Verification
The bench drives each trigger source with distinct patterns: software writes carrying different data words, external pulses both short and long-held, and pacer reloads of 3x5, 7x1 and 0x1. The gap between start pulses separates a correct cascade from one whose stages count independently or miss the 0-means-65536 rule. Triggers spaced closer than the converter latency separate overrun handling from silent restarts. Completions under polling, interrupt, DMA and both-bits-set modes separate the level interrupt from the DMA pulse and show which of the two bits takes precedence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    SRC_SOFT = 2'b00,
    SRC_PACE = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_OFF  = 2'b11
  } trig_src_e;

  localparam logic [ADDR_W-1:0] OFS_RESULT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_PACE0  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_PACE1  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_SWTRIG = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h18;

  localparam int CTRL_IRQ_BIT = 2;
  localparam int CTRL_DMA_BIT = 3;

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  // R3: an edge gives one pulse, never two in a row
  assert_one_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o)
    else $error("external edge produced a multi-cycle pulse");

endmodule

// File: rtl/adc_pacer_stage.sv
module adc_pacer_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = reload_i;
    end else if (step_i) begin
      cnt_d = at_last ? reload_i : (cnt_q - CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = run_i & step_i & at_last;

  // R2: terminal count always leads to an automatic reload
  assert_reload_at_tc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == $past(reload_i)))
    else $error("pacer stage did not reload at terminal count");

endmodule

// File: rtl/adc_pacer.sv
module adc_pacer #(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic [STAGES*CNT_W-1:0] reload_i,
  output logic                    trig_o
);

  logic [STAGES:0] step;

  assign step[0] = 1'b1;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    adc_pacer_stage #(.CNT_W(CNT_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run_i),
      .step_i   (step[g]),
      .reload_i (reload_i[g*CNT_W +: CNT_W]),
      .tick_o   (step[g+1])
    );
  end

  assign trig_o = step[STAGES];

  // R2: the pacer is silent while it is not selected
  assert_idle_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !trig_o)
    else $error("pacer fired while stopped");

endmodule

// File: rtl/adc_conv_track.sv
module adc_conv_track #(
  parameter int CONV_MAX_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic done_i,
  output logic start_o,
  output logic busy_o,
  output logic cpl_o,
  output logic ovr_o
);

  localparam int TMR_W = $clog2(CONV_MAX_CYC + 2);
  localparam logic [TMR_W-1:0] TMR_SAT = '1;

  logic             start_q, start_d;
  logic             busy_q, busy_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    start_d = trig_i & ~busy_q;
    busy_d  = start_d | (busy_q & ~done_i);
    tmr_d   = '0;
    if (busy_q) begin
      tmr_d = (tmr_q == TMR_SAT) ? tmr_q : (tmr_q + TMR_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      tmr_q   <= '0;
    end else begin
      start_q <= start_d;
      busy_q  <= busy_d;
      tmr_q   <= tmr_d;
    end
  end

  assign start_o = start_q;
  assign busy_o  = busy_q;
  assign cpl_o   = done_i & busy_q;
  assign ovr_o   = trig_i & busy_q;

  // R1: a start pulse lasts one cycle
  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q)
    else $error("start pulse wider than one cycle");

  // R9: busy covers the start pulse
  assert_busy_with_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q)
    else $error("start issued without busy");

  // R9: converter answers within the allowed window
  assert_conv_in_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tmr_q <= TMR_W'(CONV_MAX_CYC)))
    else $error("conversion exceeded its time limit");

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int REG_W        = 16,
  parameter int DATA_W       = 12,
  parameter int CONV_MAX_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ext_trig_i,
  output logic              adc_start_o,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              irq_o,
  output logic              dma_req_o
);

  localparam int STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rs_q[1];

  // register state
  trig_src_e               src_q, src_d;
  logic                    irq_en_q, irq_en_d;
  logic                    dma_en_q, dma_en_d;
  logic [STAGES*REG_W-1:0] rel_q, rel_d;
  logic [DATA_W-1:0]       data_q, data_d;
  logic                    ready_q, ready_d;
  logic                    ovr_q, ovr_d;
  logic                    dma_q, dma_d;
  logic [REG_W-1:0]        rdata_q, rdata_d;

  // decoded accesses
  logic wr_ctrl, wr_p0, wr_p1, wr_sw, rd_result, rd_status;

  assign wr_ctrl   = bus_wr & (bus_addr == OFS_CTRL);
  assign wr_p0     = bus_wr & (bus_addr == OFS_PACE0);
  assign wr_p1     = bus_wr & (bus_addr == OFS_PACE1);
  assign wr_sw     = bus_wr & (bus_addr == OFS_SWTRIG);
  assign rd_result = bus_rd & (bus_addr == OFS_RESULT);
  assign rd_status = bus_rd & (bus_addr == OFS_STATUS);

  // trigger sources
  logic ext_rise, pace_trig, trig;
  logic busy, cpl, ovr_hit;

  adc_edge_sync u_ext_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (ext_trig_i),
    .rise_o  (ext_rise)
  );

  adc_pacer #(.CNT_W(REG_W), .STAGES(STAGES)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run_i    (src_q == SRC_PACE),
    .reload_i (rel_q),
    .trig_o   (pace_trig)
  );

  always_comb begin
    unique case (src_q)
      SRC_SOFT: trig = wr_sw;
      SRC_PACE: trig = pace_trig;
      SRC_EXT:  trig = ext_rise;
      default:  trig = 1'b0;
    endcase
  end

  adc_conv_track #(.CONV_MAX_CYC(CONV_MAX_CYC)) u_track (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .trig_i  (trig),
    .done_i  (adc_done_i),
    .start_o (adc_start_o),
    .busy_o  (busy),
    .cpl_o   (cpl),
    .ovr_o   (ovr_hit)
  );

  // next state
  always_comb begin
    src_d    = src_q;
    irq_en_d = irq_en_q;
    dma_en_d = dma_en_q;
    rel_d    = rel_q;
    if (wr_ctrl) begin
      src_d    = trig_src_e'(bus_wdata[1:0]);
      irq_en_d = bus_wdata[CTRL_IRQ_BIT];
      dma_en_d = bus_wdata[CTRL_DMA_BIT];
    end
    if (wr_p0) rel_d[0 +: REG_W]     = bus_wdata;
    if (wr_p1) rel_d[REG_W +: REG_W] = bus_wdata;

    data_d  = cpl ? adc_data_i : data_q;
    ready_d = cpl ? 1'b1 : (rd_result ? 1'b0 : ready_q);
    ovr_d   = ovr_hit ? 1'b1 : (rd_status ? 1'b0 : ovr_q);
    dma_d   = cpl & dma_en_q;

    rdata_d = rdata_q;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_RESULT: rdata_d = {{(REG_W-DATA_W){1'b0}}, data_q};
        OFS_STATUS: rdata_d = {{(REG_W-3){1'b0}}, busy, ovr_q, ready_q};
        OFS_PACE0:  rdata_d = rel_q[0 +: REG_W];
        OFS_PACE1:  rdata_d = rel_q[REG_W +: REG_W];
        OFS_CTRL:   rdata_d = {{(REG_W-4){1'b0}}, dma_en_q, irq_en_q, src_q};
        default:    rdata_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_q    <= SRC_SOFT;
      irq_en_q <= 1'b0;
      dma_en_q <= 1'b0;
      rel_q    <= '0;
      data_q   <= '0;
      ready_q  <= 1'b0;
      ovr_q    <= 1'b0;
      dma_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      src_q    <= src_d;
      irq_en_q <= irq_en_d;
      dma_en_q <= dma_en_d;
      rel_q    <= rel_d;
      data_q   <= data_d;
      ready_q  <= ready_d;
      ovr_q    <= ovr_d;
      dma_q    <= dma_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign dma_req_o = dma_q;
  assign irq_o     = ready_q & irq_en_q & ~dma_en_q;

  // R4: a trigger while busy leaves the overrun bit set
  assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovr_hit |=> ovr_q)
    else $error("overrun not recorded");

  // R5: an accepted completion sets ready
  assert_ready_on_cpl_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpl |=> ready_q)
    else $error("ready not set after completion");

  // R6: a result read with no new completion drops the interrupt
  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_result && !cpl) |=> !irq_o)
    else $error("interrupt held after result read");

  // R7: a DMA request is a single-cycle pulse
  assert_dma_single_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_req_o |=> !dma_req_o)
    else $error("DMA request wider than one cycle");

  // R8: with the source off no start follows
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_q == SRC_OFF) |=> !adc_start_o)
    else $error("start issued with source off");

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

  localparam int REG_W  = 16;
  localparam int DATA_W = 12;
  localparam logic [4:0] A_RES = 5'h00, A_STAT = 5'h04, A_P0 = 5'h08,
                         A_P1 = 5'h0C, A_SW = 5'h14, A_CTRL = 5'h18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]        bus_addr = '0;
  logic [REG_W-1:0]  bus_wdata = '0;
  logic [REG_W-1:0]  bus_rdata;
  logic              ext_trig = 1'b0;
  logic              adc_start;
  logic              adc_done = 1'b0;
  logic [DATA_W-1:0] adc_data = '0;
  logic              irq, dma_req;

  always #4 clk = ~clk;  // 125 MHz

  adc_seq_ctrl #(.REG_W(REG_W), .DATA_W(DATA_W), .CONV_MAX_CYC(1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_trig_i(ext_trig), .adc_start_o(adc_start), .adc_done_i(adc_done),
    .adc_data_i(adc_data), .irq_o(irq), .dma_req_o(dma_req)
  );

  int n_chk = 0, n_fail = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // converter stand-in: done after conv_dly cycles, fresh word each time
  int conv_dly = 4;
  int cw = 0;
  logic [DATA_W-1:0] conv_val = 12'h100;

  always @(negedge clk) begin
    adc_done = 1'b0;
    if (cw > 0) begin
      cw--;
      if (cw == 0) begin
        adc_done = 1'b1;
        adc_data = conv_val;
        conv_val = conv_val + 12'h053;
      end
    end
    if (adc_start === 1'b1) cw = conv_dly;
  end

  // behavioural reference model, advanced on every rising edge
  int     m_src, m_irqen, m_dmaen;
  longint m_p0, m_p1, m_pk;
  int     m_s1, m_s2, m_s3;
  int     m_busy, m_ready, m_ovr, m_start, m_dma;
  int     m_data, m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_irqen = 0; m_dmaen = 0; m_p0 = 0; m_p1 = 0; m_pk = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_busy = 0; m_ready = 0; m_ovr = 0; m_start = 0; m_dma = 0;
      m_data = 0; m_rdata = 0;
    end else begin
      int     rise, ptrig, trig, cpl, nstart, novr;
      longint period;
      rise = (m_s2 == 1 && m_s3 == 0);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext_trig);
      period = ((m_p0 == 0) ? 65536 : m_p0) * ((m_p1 == 0) ? 65536 : m_p1);
      ptrig = 0;
      if (m_src == 1) begin
        m_pk++;
        ptrig = (m_pk % period == 0);
      end else begin
        m_pk = 0;
      end
      trig = (m_src == 0 && bus_wr && bus_addr == A_SW) ||
             (m_src == 1 && ptrig) || (m_src == 2 && rise);
      cpl    = (adc_done && m_busy);
      nstart = (trig && !m_busy);
      novr   = (trig && m_busy);
      if (bus_rd) begin
        case (bus_addr)
          A_RES:   m_rdata = m_data;
          A_STAT:  m_rdata = m_busy * 4 + m_ovr * 2 + m_ready;
          A_P0:    m_rdata = int'(m_p0);
          A_P1:    m_rdata = int'(m_p1);
          A_CTRL:  m_rdata = m_dmaen * 8 + m_irqen * 4 + m_src;
          default: m_rdata = 0;
        endcase
      end
      if (cpl) m_data = int'(adc_data);
      m_ready = cpl ? 1 : ((bus_rd && bus_addr == A_RES) ? 0 : m_ready);
      m_ovr   = novr ? 1 : ((bus_rd && bus_addr == A_STAT) ? 0 : m_ovr);
      m_dma   = (cpl && m_dmaen) ? 1 : 0;
      m_busy  = nstart ? 1 : (cpl ? 0 : m_busy);
      m_start = nstart;
      if (bus_wr && bus_addr == A_CTRL) begin
        m_src = int'(bus_wdata[1:0]); m_irqen = int'(bus_wdata[2]); m_dmaen = int'(bus_wdata[3]);
      end
      if (bus_wr && bus_addr == A_P0) m_p0 = longint'(bus_wdata);
      if (bus_wr && bus_addr == A_P1) m_p1 = longint'(bus_wdata);
    end
  end

  // per-cycle comparison and event counters
  int n_start = 0, n_dma = 0;
  longint cyc = 0, last_start = -1, gap_min = 0, gap_max = 0;

  always @(negedge clk) begin
    cyc++;
    if (model_on) begin
      chk("R1 R2 R3 R8", "adc_start", adc_start, m_start);
      chk("R6", "irq", irq, (m_ready && m_irqen && !m_dmaen));
      chk("R7", "dma_req", dma_req, m_dma);
      chk("R4 R5 R9", "bus_rdata", bus_rdata, m_rdata);
    end
    if (adc_start === 1'b1) begin
      n_start++;
      if (last_start >= 0) begin
        if (gap_min == 0 || cyc - last_start < gap_min) gap_min = cyc - last_start;
        if (cyc - last_start > gap_max) gap_max = cyc - last_start;
      end
      last_start = cyc;
    end
    if (dma_req === 1'b1) n_dma++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [REG_W-1:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic ext_pulse(input int hi, input int lo);
    @(negedge clk);
    ext_trig = 1'b1;
    idle(hi);
    ext_trig = 1'b0;
    idle(lo);
  endtask

  task automatic reset_gaps();
    last_start = -1; gap_min = 0; gap_max = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [REG_W-1:0] v;
    int s0, d0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    model_on = 1'b1;

    // R10: reset state
    chk("R10", "adc_start after reset", adc_start, 0);
    chk("R10", "irq after reset", irq, 0);
    chk("R10", "dma_req after reset", dma_req, 0);
    bus_read(A_STAT, v);
    chk("R10", "status after reset", v, 0);
    bus_read(A_CTRL, v);
    chk("R10", "control after reset", v, 0);

    // R1: software trigger, data ignored
    conv_dly = 4;
    bus_write(A_CTRL, 16'h0000);
    s0 = n_start;
    bus_write(A_SW, 16'h0000); idle(10);
    bus_write(A_SW, 16'hFFFF); idle(10);
    bus_write(A_SW, 16'h1234); idle(10);
    chk("R1", "software start count", n_start - s0, 3);

    // R5: ready set, result read clears it
    bus_read(A_STAT, v);
    chk("R5", "ready after completion", v[0], 1);
    bus_read(A_RES, v);
    chk("R5", "result word", v, 16'(conv_val - 12'h053));
    bus_read(A_STAT, v);
    chk("R5", "ready after result read", v[0], 0);

    // R4: overrun on trigger while busy, cleared by status read
    conv_dly = 30;
    s0 = n_start;
    bus_write(A_SW, 16'h0001); idle(3);
    bus_write(A_SW, 16'h0002); idle(40);
    chk("R4", "starts with overlapping trigger", n_start - s0, 1);
    bus_read(A_STAT, v);
    chk("R4", "overrun set", v[1], 1);
    bus_read(A_STAT, v);
    chk("R4", "overrun cleared by status read", v[1], 0);

    // R9: busy bit during conversion
    bus_write(A_SW, 16'h0003); idle(5);
    bus_read(A_STAT, v);
    chk("R9", "busy during conversion", v[2], 1);
    idle(40);
    bus_read(A_STAT, v);
    chk("R9", "busy after completion", v[2], 0);
    bus_read(A_RES, v);

    // R3: external edges, short and long-held
    conv_dly = 5;
    bus_write(A_CTRL, 16'h0002);
    s0 = n_start;
    for (int i = 0; i < 4; i++) ext_pulse(3, 12);
    ext_pulse(30, 12);
    chk("R3", "external start count", n_start - s0, 5);

    // R8: software write ignored while external source selected
    s0 = n_start;
    bus_write(A_SW, 16'h00AA); idle(10);
    chk("R8", "software write under external source", n_start - s0, 0);

    // R8: source off
    bus_write(A_CTRL, 16'h0003);
    s0 = n_start;
    bus_write(A_SW, 16'h0055); idle(5);
    ext_pulse(3, 12); ext_pulse(3, 12);
    chk("R8", "starts with source off", n_start - s0, 0);
    bus_read(A_RES, v);

    // R6: interrupt mode
    bus_write(A_CTRL, 16'h0004);
    bus_write(A_SW, 16'h0000); idle(10);
    chk("R6", "irq while ready", irq, 1);
    bus_read(A_RES, v);
    chk("R6", "irq after result read", irq, 0);

    // R7: DMA mode, and DMA precedence over interrupt
    bus_write(A_CTRL, 16'h0008);
    d0 = n_dma;
    bus_write(A_SW, 16'h0000); idle(10);
    bus_write(A_SW, 16'h0000); idle(10);
    chk("R7", "DMA pulses", n_dma - d0, 2);
    bus_write(A_CTRL, 16'h000C);
    d0 = n_dma;
    bus_write(A_SW, 16'h0000); idle(10);
    chk("R7", "irq with both bits set", irq, 0);
    chk("R7", "DMA pulse with both bits set", n_dma - d0, 1);
    bus_read(A_RES, v);

    // R2: pacer 3 x 5
    conv_dly = 4;
    bus_write(A_CTRL, 16'h0000);
    bus_write(A_P0, 16'd3);
    bus_write(A_P1, 16'd5);
    idle(2);
    reset_gaps();
    s0 = n_start;
    bus_write(A_CTRL, 16'h0001); idle(200);
    bus_write(A_CTRL, 16'h0003); idle(10);
    chk("R2", "pacer 3x5 min gap", gap_min, 15);
    chk("R2", "pacer 3x5 max gap", gap_max, 15);
    chk("R2", "pacer 3x5 start count", n_start - s0, 13);

    // R2: pacer 7 x 1
    bus_write(A_P0, 16'd7);
    bus_write(A_P1, 16'd1);
    idle(2);
    reset_gaps();
    bus_write(A_CTRL, 16'h0001); idle(100);
    bus_write(A_CTRL, 16'h0003); idle(10);
    chk("R2", "pacer 7x1 min gap", gap_min, 7);
    chk("R2", "pacer 7x1 max gap", gap_max, 7);

    // R2: reload 0 counts as 65536
    bus_write(A_P0, 16'd0);
    bus_write(A_P1, 16'd1);
    idle(2);
    s0 = n_start;
    bus_write(A_CTRL, 16'h0001); idle(65000);
    chk("R2", "no start before 65536 cycles", n_start - s0, 0);
    idle(1000);
    chk("R2", "one start near 65536 cycles", n_start - s0, 1);
    bus_write(A_CTRL, 16'h0003); idle(10);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule